// File: doc/BRIEF.md
# Ethernet Transmit Queue Manager

This block sits between a host processor and a MAC transmitter and owns a shared transmit packet store. The host streams each frame into the store as 16-bit words: a header word with the completion-interrupt flag and a frame tag, a length word, and then the frame bytes. The frame bytes include destination and source addresses and the length/type field, and all of them pass through unchanged. The block keeps a running count of free bytes and charges each frame for its header words and its payload, rounded up to a 4-byte boundary. It rejects frames that are empty or that do not fit, and it raises a sticky error for them.

A frame enters the queue in one of two ways. In manual mode, the host sets a self-clearing enqueue bit for each frame. In automatic mode, every completed frame is queued without further action. The transmitter sees one frame at a time through a request/done handshake that carries the frame length and tag. It fetches the payload words by offset through a read port. The host can also arm a one-shot request that pulses an interrupt once the free count reaches a threshold it supplies.

Top module: `txq_mgr`

## Requirements
- R1: After reset, `free_bytes` is 6144, and `tx_req`, `err_flag`, `enq_pending`, `space_arm_pending`, `space_irq` and `done_irq` are all 0.
- R2: Each frame is written as consecutive words on `host_wr`. Word 0 is the header: bit 15 is the completion-interrupt flag, bits 5:0 are the tag, and bits 14:6 are ignored. Word 1 is the length word: bits 10:0 give the byte count, and bits 15:11 are ignored. Then come ceil(count/2) payload words. Payload word k holds bytes 2k and 2k+1.
- R3: Committing a frame lowers `free_bytes` by floor((count+7)/4)*4 in the cycle after the frame becomes complete (or after it is enqueued). The cycle after `tx_done` returns that same amount.
- R4: With `host_auto`=0, a completed frame waits and free space does not change until a `host_enq` pulse arrives. `host_wr` words written while the frame waits are ignored. `enq_pending` goes to 1 after the pulse and returns to 0 after that frame's `tx_done`.
- R5: With `host_auto`=1, each completed frame is queued without a command. Several frames may be queued, and they are offered in the order in which they were written.
- R6: A frame with a byte count of 0, or with a charge larger than the current free space, is dropped. `err_flag` is set and stays set until reset, `free_bytes` is unchanged, and no request is made for the frame.
- R7: `tx_req` rises with `tx_len` equal to the byte count and `tx_fid` equal to the tag. These stay steady until `tx_done` is sampled high, and `tx_req` is low in the following cycle.
- R8: When the flag in header bit 15 is 1, `done_irq` pulses for one cycle after `tx_done`, and `done_fid` then holds the tag. When the flag is 0, there is no pulse.
- R9: A `host_space_arm` pulse latches `host_space_req` and sets `space_arm_pending`. In the first cycle after that in which `free_bytes` is at least the latched value, `space_irq` pulses for one cycle and `space_arm_pending` clears.
- R10: While `tx_req` is high, `mac_rd_data` returns payload word `mac_rd_off` of the offered frame one cycle after the offset is presented. This holds across the wrap of the circular store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host word write strobe |
| host_wdata | input | 16 | Host word |
| host_auto | input | 1 | 1 = automatic queuing, 0 = manual |
| host_enq | input | 1 | Manual enqueue pulse |
| host_space_arm | input | 1 | Arm the free-space interrupt |
| host_space_req | input | 13 | Free-space threshold in bytes |
| free_bytes | output | 13 | Current free space in bytes |
| enq_pending | output | 1 | Manual enqueue bit, self-clearing |
| space_arm_pending | output | 1 | Space request armed, self-clearing |
| space_irq | output | 1 | One-cycle free-space interrupt |
| done_irq | output | 1 | One-cycle completion interrupt |
| done_fid | output | 6 | Tag of the last frame that raised `done_irq` |
| err_flag | output | 1 | Sticky frame-rejected flag |
| tx_req | output | 1 | Frame offered to the transmitter |
| tx_len | output | 11 | Byte count of the offered frame |
| tx_fid | output | 6 | Tag of the offered frame |
| tx_done | input | 1 | Transmitter finished the offered frame |
| mac_rd_off | input | 10 | Payload word offset to read |
| mac_rd_data | output | 16 | Payload word, one cycle after the offset |

## Verification
If the write or read pointer slips, the next frame's length and tag appear wrong on `tx_len`/`tx_fid` at its request, and the payload read back one cycle later no longer matches. A frame parsed on the wrong word boundary shows up the same way, one frame later. Errors in the space count appear on `free_bytes` in the cycle after a commit or a completion. Because the bench sweeps byte counts through every rounding remainder and walks frames around the ring wrap, such errors cannot hide. A mis-armed threshold or a completion flag lost in the header shows within one cycle as a missing or extra `space_irq`/`done_irq` pulse.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int HW      = 16;
  localparam int LEN_W   = 11;
  localparam int FID_W   = 6;
  localparam int NEED_W  = LEN_W + 1;
  localparam int IOC_BIT = 15;

  typedef enum logic [1:0] {RD_IDLE, RD_CTRL, RD_LEN, RD_SEND} rd_state_t;

  // bytes charged for a frame: two header words plus payload, to a 4-byte multiple
  function automatic logic [NEED_W-1:0] need_bytes(input logic [LEN_W-1:0] bc);
    logic [NEED_W-1:0] t;
    t = {1'b0, bc} + NEED_W'(7);
    return {t[NEED_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/txq_ram.sv
module txq_ram #(
  parameter int DEPTH = 3072,
  parameter int AW    = 12,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txq_writer.sv
module txq_writer
  import txq_pkg::*;
#(
  parameter int WORDS = 3072,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_len_bits,
  input  logic             resolve,
  input  logic             accept_ok,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic             ready,
  output logic [LEN_W-1:0] bc
);
  logic [AW-1:0]  start;
  logic [LEN_W:0] idx;
  logic [LEN_W:0] last_idx;
  logic           take;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a, input logic [AW:0] inc);
    logic [AW:0] s;
    s = {1'b0, a} + inc;
    if (s >= (AW+1)'(WORDS)) s = s - (AW+1)'(WORDS);
    return s[AW-1:0];
  endfunction

  assign take     = wr_en & ~ready;
  assign we       = take;
  assign waddr    = wrap(start, (AW+1)'(idx));
  assign last_idx = (({1'b0, bc} + 1'b1) >> 1) + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= '0;
      idx   <= '0;
      ready <= 1'b0;
      bc    <= '0;
    end else if (resolve) begin
      ready <= 1'b0;
      idx   <= '0;
      if (accept_ok) start <= wrap(start, (AW+1)'(need_bytes(bc) >> 1));
    end else if (take) begin
      idx <= idx + 1'b1;
      if (idx == (LEN_W+1)'(1)) begin
        bc <= wr_len_bits;
        if (wr_len_bits == '0) ready <= 1'b1;
      end else if (idx > (LEN_W+1)'(1) && idx == last_idx) begin
        ready <= 1'b1;
      end
    end
  end

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(we));
endmodule

// File: rtl/txq_reader.sv
module txq_reader
  import txq_pkg::*;
#(
  parameter int WORDS = 3072,
  parameter int AW    = 12,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             have_frame,
  input  logic [HW-1:0]    rdata,
  input  logic             tx_done,
  input  logic [OFF_W-1:0] mac_off,
  output logic [AW-1:0]    raddr,
  output logic             tx_req,
  output logic [LEN_W-1:0] tx_len,
  output logic [FID_W-1:0] tx_fid,
  output logic             fin,
  output logic             fin_ioc
);
  rd_state_t   st;
  logic [AW-1:0] rd_ptr;
  logic        ioc;
  logic        hdr_unused;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] a, input logic [AW:0] inc);
    logic [AW:0] s;
    s = {1'b0, a} + inc;
    if (s >= (AW+1)'(WORDS)) s = s - (AW+1)'(WORDS);
    return s[AW-1:0];
  endfunction

  assign hdr_unused = ^rdata[IOC_BIT-1:LEN_W];
  assign fin        = (st == RD_SEND) & tx_done;
  assign fin_ioc    = ioc;

  always_comb begin
    case (st)
      RD_CTRL: raddr = wrap(rd_ptr, (AW+1)'(1));
      RD_SEND: raddr = wrap(rd_ptr, (AW+1)'(mac_off) + (AW+1)'(2));
      default: raddr = rd_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RD_IDLE;
      rd_ptr <= '0;
      tx_req <= 1'b0;
      tx_len <= '0;
      tx_fid <= '0;
      ioc    <= 1'b0;
    end else begin
      case (st)
        RD_IDLE: if (have_frame) st <= RD_CTRL;
        RD_CTRL: begin
          ioc    <= rdata[IOC_BIT];
          tx_fid <= rdata[FID_W-1:0];
          st     <= RD_LEN;
        end
        RD_LEN: begin
          tx_len <= rdata[LEN_W-1:0];
          tx_req <= 1'b1;
          st     <= RD_SEND;
        end
        default: if (tx_done) begin
          tx_req <= 1'b0;
          rd_ptr <= wrap(rd_ptr, (AW+1)'(need_bytes(tx_len) >> 1));
          st     <= RD_IDLE;
        end
      endcase
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_len) && $stable(tx_fid)));
endmodule

// File: rtl/txq_mgr.sv
module txq_mgr
  import txq_pkg::*;
#(
  parameter int BUF_BYTES = 6144,
  localparam int WORDS  = BUF_BYTES / 2,
  localparam int AW     = $clog2(WORDS),
  localparam int FREE_W = $clog2(BUF_BYTES + 1),
  localparam int OFF_W  = LEN_W - 1,
  localparam int Q_W    = $clog2(BUF_BYTES / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [HW-1:0]     host_wdata,
  input  logic              host_auto,
  input  logic              host_enq,
  input  logic              host_space_arm,
  input  logic [FREE_W-1:0] host_space_req,
  output logic [FREE_W-1:0] free_bytes,
  output logic              enq_pending,
  output logic              space_arm_pending,
  output logic              space_irq,
  output logic              done_irq,
  output logic [FID_W-1:0]  done_fid,
  output logic              err_flag,
  output logic              tx_req,
  output logic [LEN_W-1:0]  tx_len,
  output logic [FID_W-1:0]  tx_fid,
  input  logic              tx_done,
  input  logic [OFF_W-1:0]  mac_rd_off,
  output logic [HW-1:0]     mac_rd_data
);
  logic              we, frm_ready, fin, fin_ioc;
  logic [AW-1:0]     waddr, raddr;
  logic [LEN_W-1:0]  frm_bc;
  logic [FREE_W-1:0] free, req_q, take_b, give_b;
  logic [Q_W-1:0]    queued;
  logic              inflight, commit_go, bad, ok, rej;
  logic [NEED_W-1:0] need_c;

  txq_ram #(.DEPTH(WORDS), .AW(AW), .DW(HW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(host_wdata),
    .raddr(raddr), .rdata(mac_rd_data)
  );

  txq_writer #(.WORDS(WORDS), .AW(AW)) u_wr (
    .clk(clk), .rst(rst), .wr_en(host_wr), .wr_len_bits(host_wdata[LEN_W-1:0]),
    .resolve(commit_go), .accept_ok(ok), .we(we), .waddr(waddr),
    .ready(frm_ready), .bc(frm_bc)
  );

  txq_reader #(.WORDS(WORDS), .AW(AW), .OFF_W(OFF_W)) u_rd (
    .clk(clk), .rst(rst), .have_frame(queued != '0), .rdata(mac_rd_data),
    .tx_done(tx_done), .mac_off(mac_rd_off), .raddr(raddr), .tx_req(tx_req),
    .tx_len(tx_len), .tx_fid(tx_fid), .fin(fin), .fin_ioc(fin_ioc)
  );

  assign commit_go = frm_ready & (host_auto | (enq_pending & ~inflight));
  assign need_c    = need_bytes(frm_bc);
  assign bad       = (frm_bc == '0) | (FREE_W'(need_c) > free);
  assign ok        = commit_go & ~bad;
  assign rej       = commit_go & bad;
  assign take_b    = ok  ? FREE_W'(need_c) : '0;
  assign give_b    = fin ? FREE_W'(need_bytes(tx_len)) : '0;
  assign free_bytes = free;

  always_ff @(posedge clk) begin
    if (rst) begin
      free              <= FREE_W'(BUF_BYTES);
      queued            <= '0;
      err_flag          <= 1'b0;
      inflight          <= 1'b0;
      enq_pending       <= 1'b0;
      space_arm_pending <= 1'b0;
      space_irq         <= 1'b0;
      req_q             <= '0;
      done_irq          <= 1'b0;
      done_fid          <= '0;
    end else begin
      free   <= free - take_b + give_b;
      queued <= queued + Q_W'(ok) - Q_W'(fin);
      if (rej) err_flag <= 1'b1;

      if (ok && !host_auto) inflight <= 1'b1;
      else if (fin)         inflight <= 1'b0;

      if ((fin && inflight) || (rej && !host_auto)) enq_pending <= 1'b0;
      else if (host_enq && !host_auto)             enq_pending <= 1'b1;

      if (host_space_arm) begin
        space_arm_pending <= 1'b1;
        req_q             <= host_space_req;
        space_irq         <= 1'b0;
      end else if (space_arm_pending && free >= req_q) begin
        space_arm_pending <= 1'b0;
        space_irq         <= 1'b1;
      end else begin
        space_irq <= 1'b0;
      end

      done_irq <= fin & fin_ioc;
      if (fin && fin_ioc) done_fid <= tx_fid;
    end
  end

  // R3
  free_cap_chk: assert property (@(posedge clk) disable iff (rst)
    free <= FREE_W'(BUF_BYTES));
  // R6
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_go && frm_bc == '0) |=> err_flag);
  // R9
  space_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    space_irq |=> !space_irq);
  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(tx_done));
  // R5
  q_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (queued != '0));
endmodule

// File: tb/txq_mgr_test.sv
module txq_mgr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_auto = 1'b1, host_enq = 1'b0, host_space_arm = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [12:0] host_space_req = '0;
  logic [12:0] free_bytes;
  logic        enq_pending, space_arm_pending, space_irq, done_irq, err_flag, tx_req;
  logic [5:0]  done_fid, tx_fid;
  logic [10:0] tx_len;
  logic        tx_done = 1'b0;
  logic [9:0]  mac_rd_off = '0;
  logic [15:0] mac_rd_data;
  int checks = 0, fails = 0;

  txq_mgr uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_auto(host_auto), .host_enq(host_enq), .host_space_arm(host_space_arm),
    .host_space_req(host_space_req), .free_bytes(free_bytes), .enq_pending(enq_pending),
    .space_arm_pending(space_arm_pending), .space_irq(space_irq), .done_irq(done_irq),
    .done_fid(done_fid), .err_flag(err_flag), .tx_req(tx_req), .tx_len(tx_len),
    .tx_fid(tx_fid), .tx_done(tx_done), .mac_rd_off(mac_rd_off), .mac_rd_data(mac_rd_data)
  );

  always #5 clk = ~clk;

  function automatic int need(int bc);
    return ((bc + 7) / 4) * 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // ends two cycles after the last word, so any commit has taken effect
  task automatic write_frame(int ioc, int fid, int bc, int seed);
    host_wr = 1'b1;
    host_wdata = {ioc[0], 9'h1A5, fid[5:0]};
    @(negedge clk);
    host_wdata = {5'b10101, bc[10:0]};
    @(negedge clk);
    for (int k = 0; k < (bc + 1) / 2; k++) begin
      host_wdata = 16'(seed + k * 3);
      @(negedge clk);
    end
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic serve(int len, int fid, int ioc, int seed, bit chkdata);
    while (!tx_req) @(negedge clk);
    chk("R7 len", int'(tx_len), len);
    chk("R7 fid", int'(tx_fid), fid);
    if (chkdata)
      for (int k = 0; k < (len + 1) / 2; k++) begin
        mac_rd_off = 10'(k);
        @(negedge clk);
        chk("R10 data", int'(mac_rd_data), int'(16'(seed + k * 3)));
      end
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R7 req drop", int'(tx_req), 0);
    chk("R8 done_irq", int'(done_irq), ioc);
    if (ioc != 0) chk("R8 done_fid", int'(done_fid), fid);
  endtask

  task automatic arm(int req);
    host_space_arm = 1'b1;
    host_space_req = 13'(req);
    @(negedge clk);
    host_space_arm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 free", int'(free_bytes), 6144);
    chk("R1 tx_req", int'(tx_req), 0);
    chk("R1 err", int'(err_flag), 0);
    chk("R1 enq", int'(enq_pending), 0);
    chk("R1 arm", int'(space_arm_pending), 0);
    chk("R1 irq", int'(space_irq) + int'(done_irq), 0);

    // R2 R3 R8: byte-count sweep in automatic mode
    for (int bc = 1; bc <= 64; bc++) begin
      write_frame(bc % 2, bc % 64, bc, bc * 17);
      chk("R3 charge", int'(free_bytes), 6144 - need(bc));
      serve(bc, bc % 64, bc % 2, bc * 17, 1'b1);
      chk("R3 return", int'(free_bytes), 6144);
    end
    // R10: large frames carry the pointers around the ring
    for (int i = 0; i < 6; i++) begin
      int bc = 2047 - i * 211;
      write_frame(1, 40 + i, bc, i * 1001);
      chk("R3 charge big", int'(free_bytes), 6144 - need(bc));
      serve(bc, 40 + i, 1, i * 1001, 1'b1);
      chk("R3 return big", int'(free_bytes), 6144);
    end
    // R5: several frames queued, offered in order
    write_frame(1, 11, 10, 500);
    write_frame(0, 12, 21, 600);
    write_frame(1, 13, 30, 700);
    chk("R5 queued free", int'(free_bytes), 6144 - need(10) - need(21) - need(30));
    serve(10, 11, 1, 500, 1'b1);
    serve(21, 12, 0, 600, 1'b1);
    serve(30, 13, 1, 700, 1'b1);
    chk("R5 drained", int'(free_bytes), 6144);

    // R6: zero byte count
    do_reset();
    write_frame(1, 5, 0, 0);
    chk("R6 zero err", int'(err_flag), 1);
    chk("R6 zero free", int'(free_bytes), 6144);
    repeat (6) @(negedge clk);
    chk("R6 zero no req", int'(tx_req), 0);
    write_frame(1, 6, 5, 77);
    chk("R6 next ok", int'(free_bytes), 6144 - need(5));
    chk("R6 sticky", int'(err_flag), 1);
    serve(5, 6, 1, 77, 1'b1);

    // R6 R9: overflow and space interrupt
    do_reset();
    write_frame(1, 1, 2047, 100);
    write_frame(1, 2, 2047, 200);
    chk("R6 two fit", int'(free_bytes), 6144 - 2 * need(2047));
    chk("R6 no err yet", int'(err_flag), 0);
    write_frame(1, 3, 2047, 300);
    chk("R6 overflow err", int'(err_flag), 1);
    chk("R6 overflow free", int'(free_bytes), 6144 - 2 * need(2047));
    arm(4000);
    chk("R9 armed", int'(space_arm_pending), 1);
    chk("R9 no irq", int'(space_irq), 0);
    serve(2047, 1, 1, 100, 1'b0);
    chk("R9 free after", int'(free_bytes), 6144 - need(2047));
    @(negedge clk);
    chk("R9 irq", int'(space_irq), 1);
    chk("R9 disarm", int'(space_arm_pending), 0);
    @(negedge clk);
    chk("R9 pulse", int'(space_irq), 0);
    arm(6144);
    serve(2047, 2, 1, 200, 1'b1);
    @(negedge clk);
    chk("R9 irq full", int'(space_irq), 1);
    arm(100);
    @(negedge clk);
    chk("R9 irq immediate", int'(space_irq), 1);
    arm(7000);
    repeat (10) @(negedge clk);
    chk("R9 unreachable", int'(space_irq), 0);
    chk("R9 still armed", int'(space_arm_pending), 1);

    // R4: manual mode
    do_reset();
    host_auto = 1'b0;
    write_frame(1, 33, 9, 900);
    repeat (4) @(negedge clk);
    chk("R4 held free", int'(free_bytes), 6144);
    chk("R4 held req", int'(tx_req), 0);
    chk("R4 enq idle", int'(enq_pending), 0);
    host_wr = 1'b1;
    host_wdata = 16'hDEAD;
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
    host_enq = 1'b1;
    @(negedge clk);
    host_enq = 1'b0;
    @(negedge clk);
    chk("R4 enq set", int'(enq_pending), 1);
    chk("R4 charged", int'(free_bytes), 6144 - need(9));
    serve(9, 33, 1, 900, 1'b1);
    chk("R4 enq clear", int'(enq_pending), 0);
    write_frame(0, 34, 4, 950);
    repeat (3) @(negedge clk);
    chk("R4 second held", int'(tx_req), 0);
    host_enq = 1'b1;
    @(negedge clk);
    host_enq = 1'b0;
    serve(4, 34, 0, 950, 1'b1);
    chk("R4 second clear", int'(enq_pending), 0);
    chk("R4 free back", int'(free_bytes), 6144);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule